// File: doc/BRIEF.md
# Four-Queue FIFO Read Port with Switch Pipeline

This block is the read side of a storage block that holds four FIFO queues, all on one clock. A 6-bit read address selects the queue to read. The low two bits name the queue, bit 2 picks a null queue that holds no data, and the top three bits must equal the block's fixed device ID before the selection takes effect. A selection is captured only while the address strobe is high, and only once configuration has finished, which a programming-done input reports.

Changing queues runs a fixed two-edge sequence that ignores the read enable. On the first edge one word is drained from the old queue. On the second edge the first word of the new queue falls through to the output. Outside that sequence, the active-low read enable pops the selected queue on each edge, and the popped word is registered onto the 36-bit output. A separate flag strobe latches which device owns the flag bus and leaves the read selection alone. Each queue has a small internal FIFO with its own write port, so data can be loaded.

Top module: `mq_read_port`

## Requirements
- R1: After reset the selected queue is queue 0 (not null), `dout` is zero, `flag_owner` reflects a latched device field of 0, and `sel_empty` is high because every queue is empty.
- R2: A select takes effect only when `rd_addr[5:3]` equals `dev_id`. Then `rd_addr[2]`=1 selects the null queue, and otherwise `rd_addr[1:0]` selects queue 0 to 3. A select with a mismatched ID changes nothing.
- R3: A selection is captured on a rising edge only when `addr_en` is high, `prog_done` is high and no switch sequence is running. A strobe during the two switch edges is ignored.
- R4: On the edge that captures a selection, the previously selected queue is popped if `rd_en_n` is low.
- R5: On the first edge after a select, one word is popped from the previous queue whatever `rd_en_n` is.
- R6: On the second edge after a select, the first word of the new queue is popped onto `dout` whatever `rd_en_n` is.
- R7: Outside the switch sequence, the selected queue is popped on an edge only when `rd_en_n` is low. At most one queue is popped per edge, and each pop loads the popped word into `dout` on that edge.
- R8: While the null queue is selected, no queue is popped, `dout` holds its value and `sel_empty` is high.
- R9: `sel_empty` is high when the selected queue holds no word. A pop of an empty queue is ignored, and `dout` holds.
- R10: On an edge with `flag_strobe` high, `rd_addr[5:3]` is latched as the flag-bus device, and `flag_owner` goes high exactly when it equals `dev_id`. `rd_addr[2:0]` and the read selection are unaffected.
- R11: A write with `wr_en` high pushes `wr_data` into queue `wr_queue` (DEPTH words each). A write to a full queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_done | input | 1 | Configuration finished; selections allowed |
| dev_id | input | 3 | Fixed device ID |
| rd_addr | input | 6 | Read address: [5:3] device, [2] null, [1:0] queue |
| addr_en | input | 1 | Address strobe for queue selection |
| rd_en_n | input | 1 | Active-low read enable |
| flag_strobe | input | 1 | Latches the flag-bus device from rd_addr[5:3] |
| wr_en | input | 1 | Write strobe |
| wr_queue | input | 2 | Queue to write |
| wr_data | input | 36 | Write word |
| dout | output | 36 | Registered read data |
| sel_empty | output | 1 | Selected queue has no word (or is null) |
| flag_owner | output | 1 | Latched flag device equals dev_id |

## Verification
The assertions assume that `addr_en` and `flag_strobe` are never high on the same edge. The stimulus drives each strobe in its own cycle, and it drives inputs at the falling edge so they are stable at the rising edge. The reference model in the bench follows the rules above, including the case where a queue is read and written on the same edge. The stimulus also deliberately drives strobes that must be ignored: during a switch, before programming is done, and with a wrong ID.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int QSEL_W = 2;
  localparam int ID_W   = 3;
  localparam int ADDR_W = QSEL_W + 1 + ID_W;
  localparam int NQ     = 1 << QSEL_W;

  typedef enum logic [1:0] {
    SW_IDLE      = 2'd0,
    SW_FALL_NEW  = 2'd1,
    SW_DRAIN_OLD = 2'd2
  } sw_stage_t;

  function automatic logic [QSEL_W-1:0] addr_queue(input logic [ADDR_W-1:0] a);
    return a[QSEL_W-1:0];
  endfunction

  function automatic logic addr_null(input logic [ADDR_W-1:0] a);
    return a[QSEL_W];
  endfunction

  function automatic logic [ID_W-1:0] addr_dev(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: ID_W];
  endfunction
endpackage

// File: rtl/mq_fifo.sv
module mq_fifo #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [AW:0]       cnt;
  logic              do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R9
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full); // R11
endmodule

// File: rtl/mq_sel_ctrl.sv
module mq_sel_ctrl
  import mq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_done,
  input  logic [ID_W-1:0]   dev_id,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              addr_en,
  input  logic              rd_en_n,
  input  logic              flag_strobe,
  output logic [QSEL_W-1:0] cur_q,
  output logic              cur_null,
  output logic              pop_go,
  output logic [QSEL_W-1:0] pop_q,
  output logic              sel_take,
  output sw_stage_t         sw_stage,
  output logic [ID_W-1:0]   flag_dev
);
  logic [QSEL_W-1:0] prev_q;
  logic              prev_null;
  logic              pop_req, tgt_null;

  assign sel_take = addr_en && prog_done && !flag_strobe &&
                    (sw_stage == SW_IDLE) && (addr_dev(rd_addr) == dev_id);

  always_comb begin
    unique case (sw_stage)
      SW_DRAIN_OLD: begin pop_req = 1'b1;     pop_q = prev_q; tgt_null = prev_null; end
      SW_FALL_NEW:  begin pop_req = 1'b1;     pop_q = cur_q;  tgt_null = cur_null;  end
      default:      begin pop_req = !rd_en_n; pop_q = cur_q;  tgt_null = cur_null;  end
    endcase
  end
  assign pop_go = pop_req && !tgt_null;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= '0;
      cur_null  <= 1'b0;
      prev_q    <= '0;
      prev_null <= 1'b0;
      sw_stage  <= SW_IDLE;
      flag_dev  <= '0;
    end else begin
      if (sel_take) begin
        prev_q    <= cur_q;
        prev_null <= cur_null;
        cur_q     <= addr_queue(rd_addr);
        cur_null  <= addr_null(rd_addr);
        sw_stage  <= SW_DRAIN_OLD;
      end else if (sw_stage == SW_DRAIN_OLD) begin
        sw_stage  <= SW_FALL_NEW;
      end else if (sw_stage == SW_FALL_NEW) begin
        sw_stage  <= SW_IDLE;
      end
      if (flag_strobe) flag_dev <= addr_dev(rd_addr);
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_en && flag_strobe)); // R10
  AST_SWITCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stage == SW_DRAIN_OLD) |=> (sw_stage == SW_FALL_NEW)); // R6
  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_done |=> ($stable(cur_q) && $stable(cur_null))); // R3
  AST_FLAG_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_strobe && !addr_en) |=> ($stable(cur_q) && $stable(cur_null))); // R10
  AST_SWITCH_FORCES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stage != SW_IDLE) |-> pop_req); // R5
endmodule

// File: rtl/mq_read_port.sv
module mq_read_port
  import mq_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_done,
  input  logic [ID_W-1:0]   dev_id,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              addr_en,
  input  logic              rd_en_n,
  input  logic              flag_strobe,
  input  logic              wr_en,
  input  logic [QSEL_W-1:0] wr_queue,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dout,
  output logic              sel_empty,
  output logic              flag_owner
);
  logic [QSEL_W-1:0] cur_q, pop_q;
  logic              cur_null, pop_go, sel_take;
  sw_stage_t         sw_stage;
  logic [ID_W-1:0]   flag_dev;
  logic [DATA_W-1:0] heads [NQ];
  logic [NQ-1:0]     q_empty, q_full, q_push, q_pop;
  logic              pop_fire;

  mq_sel_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .prog_done(prog_done), .dev_id(dev_id),
    .rd_addr(rd_addr), .addr_en(addr_en), .rd_en_n(rd_en_n),
    .flag_strobe(flag_strobe), .cur_q(cur_q), .cur_null(cur_null),
    .pop_go(pop_go), .pop_q(pop_q), .sel_take(sel_take),
    .sw_stage(sw_stage), .flag_dev(flag_dev)
  );

  for (genvar i = 0; i < NQ; i++) begin : g_q
    assign q_push[i] = wr_en && (wr_queue == QSEL_W'(i));
    assign q_pop[i]  = pop_go && (pop_q == QSEL_W'(i)) && !q_empty[i];
    mq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(q_push[i]), .push_data(wr_data),
      .pop(q_pop[i]), .head(heads[i]), .empty(q_empty[i]), .full(q_full[i])
    );
  end

  assign pop_fire   = |q_pop;
  assign sel_empty  = cur_null || q_empty[cur_q];
  assign flag_owner = (flag_dev == dev_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dout <= '0;
    else if (pop_fire) dout <= heads[pop_q];
  end

  AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_pop)); // R7
  AST_NULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_null && sw_stage == SW_IDLE) |=> $stable(dout)); // R8
  AST_NULL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cur_null |-> sel_empty); // R8
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_fire) |=> $stable(dout)); // R9
  AST_IDLE_NEEDS_REN: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stage == SW_IDLE && rd_en_n) |-> !pop_fire); // R7
endmodule

// File: tb/mq_read_port_test.sv
module mq_read_port_test;
  localparam int DW = 36;
  localparam int DEPTH = 8;
  localparam logic [2:0] DEV = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_done = 1'b1, addr_en = 1'b0, rd_en_n = 1'b1, flag_strobe = 1'b0, wr_en = 1'b0;
  logic [5:0] rd_addr = '0;
  logic [1:0] wr_queue = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] dout;
  logic sel_empty, flag_owner;

  always #2 clk = ~clk;

  mq_read_port #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .prog_done(prog_done), .dev_id(DEV),
    .rd_addr(rd_addr), .addr_en(addr_en), .rd_en_n(rd_en_n),
    .flag_strobe(flag_strobe), .wr_en(wr_en), .wr_queue(wr_queue),
    .wr_data(wr_data), .dout(dout), .sel_empty(sel_empty), .flag_owner(flag_owner)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0] mq [4][$];
  logic [1:0] m_cur = 0, m_prev = 0;
  logic m_null = 0, m_prev_null = 0;
  int m_sw = 0;
  logic [DW-1:0] m_dout = '0;
  logic [2:0] m_flag = '0;

  // scoreboard
  logic [DW-1:0] e_dout [$];
  logic e_empty [$];
  logic e_owner [$];
  string e_tag [$];

  function automatic logic [DW-1:0] mk(input int q, input int k);
    return {4'(q), 8'hA5, 24'(k * 7 + 1)};
  endfunction

  task automatic step(input logic [5:0] a, input logic aen, input logic ren_n,
                      input logic fstr, input logic prog, input logic we,
                      input logic [1:0] wq, input logic [DW-1:0] wd, input string tag);
    logic sel, req, tnull, pop_ok, push_ok;
    logic [1:0] tq;
    @(negedge clk);
    rd_addr = a; addr_en = aen; rd_en_n = ren_n; flag_strobe = fstr;
    prog_done = prog; wr_en = we; wr_queue = wq; wr_data = wd;
    sel = aen && prog && !fstr && m_sw == 0 && a[5:3] == DEV;
    if (m_sw == 2) begin req = 1; tq = m_prev; tnull = m_prev_null; end
    else if (m_sw == 1) begin req = 1; tq = m_cur; tnull = m_null; end
    else begin req = !ren_n; tq = m_cur; tnull = m_null; end
    pop_ok  = req && !tnull && mq[tq].size() > 0;
    push_ok = we && mq[wq].size() < DEPTH;
    if (pop_ok) m_dout = mq[tq].pop_front();
    if (push_ok) mq[wq].push_back(wd);
    if (sel) begin
      m_prev = m_cur; m_prev_null = m_null;
      m_cur = a[1:0]; m_null = a[2]; m_sw = 2;
    end else if (m_sw > 0) m_sw = m_sw - 1;
    if (fstr) m_flag = a[5:3];
    e_dout.push_back(m_dout);
    e_empty.push_back(m_null || mq[m_cur].size() == 0);
    e_owner.push_back(m_flag == DEV);
    e_tag.push_back(tag);
  endtask

  task automatic idle(input string tag);  step(0, 0, 1, 0, 1, 0, 0, 0, tag); endtask
  task automatic rd(input string tag);    step(0, 0, 0, 0, 1, 0, 0, 0, tag); endtask
  task automatic wr(input int q, input logic [DW-1:0] d, input string tag);
    step(0, 0, 1, 0, 1, 1, 2'(q), d, tag);
  endtask
  task automatic sel(input logic [5:0] a, input logic ren_n, input logic prog, input string tag);
    step(a, 1, ren_n, 0, prog, 0, 0, 0, tag);
  endtask
  task automatic flag(input logic [5:0] a, input string tag);
    step(a, 0, 1, 1, 1, 0, 0, 0, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (e_tag.size() > 0) begin
      logic [DW-1:0] xd; logic xe, xo; string t;
      xd = e_dout.pop_front(); xe = e_empty.pop_front();
      xo = e_owner.pop_front(); t = e_tag.pop_front();
      checks += 3;
      if (dout !== xd) begin errors++; $display("FAIL %s dout: got %h exp %h", t, dout, xd); end
      if (sel_empty !== xe) begin errors++; $display("FAIL %s sel_empty: got %b exp %b", t, sel_empty, xe); end
      if (flag_owner !== xo) begin errors++; $display("FAIL %s flag_owner: got %b exp %b", t, flag_owner, xo); end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    for (int q = 0; q < 4; q++)
      for (int k = 0; k < 3; k++) wr(q, mk(q, k), "R11 load, R7 no read");
    rd("R7 read q0");
    idle("R7 hold");
    sel({DEV, 1'b0, 2'd2}, 0, 1, "R4 old read on select edge");
    idle("R5 drain old");
    idle("R6 new falls through");
    idle("R7 idle after switch");
    sel({3'd1, 1'b0, 2'd1}, 1, 1, "R2 wrong id");
    rd("R2 still q2");
    sel({DEV, 1'b0, 2'd1}, 1, 0, "R3 prog not done");
    rd("R3 still q2");
    rd("R9 empty read ignored");
    sel({DEV, 1'b0, 2'd3}, 1, 1, "R4 select q3");
    sel({DEV, 1'b0, 2'd1}, 1, 1, "R3 strobe during switch, R5 empty old");
    idle("R6 q3 first word");
    rd("R7 q3 read");
    flag({3'd2, 3'b111}, "R10 other device");
    rd("R10 selection kept");
    flag({DEV, 3'b010}, "R10 own device");
    sel({DEV, 1'b1, 2'd0}, 0, 1, "R4 select null");
    idle("R8 switch to null");
    idle("R8 null");
    rd("R8 null read holds");
    wr(0, mk(0, 9), "R8 write while null");
    sel({DEV, 1'b0, 2'd0}, 1, 1, "R6 leave null");
    idle("R5 null old no pop");
    idle("R6 q0 falls through");
    for (int k = 3; k < 10; k++) wr(1, mk(1, k), "R11 fill and overflow");
    sel({DEV, 1'b0, 2'd1}, 1, 1, "R2 select q1");
    idle("R5"); idle("R6 q1 first");
    for (int k = 0; k < 9; k++) rd("R9 drain q1");
    idle("R9 end");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule